// File: doc/BRIEF.md
# Two-Way Processor Mailbox with Handshake Flags

This block connects a main processor and a second processor through two single-byte mailboxes, one for each direction. A write from either side latches a byte into the mailbox that points at the other side; a read from the other side returns that byte. Each mailbox has two handshake flags. The sent flag sets on a write and clears on the matching read. The taken flag clears on a write and sets on the matching read. Each processor polls these flags through a small status word to learn whether its last byte was collected and whether a new byte is waiting.

A write from the main side also raises a one-clock non-maskable interrupt pulse toward the second processor, so that processor does not have to poll for incoming bytes. While the main side holds the second processor in reset, all handshake flags are forced to zero. The byte latches keep their contents during that reset. A build parameter declares whether the second processor is fitted at all. When it is not, the status word on the second side reads as zero.

All state is held in registers behind a synchronous active-high reset. Read data, flags and the interrupt pulse all appear one clock after the strobe that causes them.

Top module: `ipc_mailbox`

## Requirements
- R1: After `rst`, both byte latches, both read-data outputs, all four flags and `s_nmi` are zero.
- R2: A main write (`m_wr`) latches `m_wdata` for the second side. From the next cycle, main-sent (`s_status[0]`) is 1 and second-taken (`m_status[3]`) is 0.
- R3: `s_nmi` is high for exactly the one cycle that follows each cycle with `m_wr` high, and is low otherwise.
- R4: A second-side read (`s_rd`) places the latched main byte on `s_rdata` in the next cycle. It also sets second-taken (`m_status[3]`) and clears main-sent (`s_status[0]`).
- R5: A second-side write (`s_wr`) latches `s_wdata` for the main side. From the next cycle, second-sent (`m_status[2]`) is 1 and main-taken (`s_status[1]`) is 0.
- R6: A main read (`m_rd`) places the latched second-side byte on `m_rdata` in the next cycle. It also sets main-taken (`s_status[1]`) and clears second-sent (`m_status[2]`).
- R7: When a write and the matching read of the same mailbox fall in the same cycle, the flags follow the write. The read returns the byte that was latched before that write.
- R8: While `s_rst` is high, all four flags are zero from the next cycle on, whatever strobes are applied. The byte latches keep their values.
- R9: Status layout: `m_status[3]` = second-taken, `m_status[2]` = second-sent, `m_status[1:0]` = 0, `s_status[1]` = main-taken, `s_status[0]` = main-sent.
- R10: With `SUB_PRESENT` = 0, `s_status` always reads 0, and the main side still works.
- R11: A new write replaces the latched byte even if the previous byte was never read.
- R12: `m_rdata` and `s_rdata` hold their last value in cycles without a read of their mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_wr | input | 1 | Main-side write strobe |
| m_rd | input | 1 | Main-side read strobe |
| m_wdata | input | DATA_W | Main-side write data |
| s_wr | input | 1 | Second-side write strobe |
| s_rd | input | 1 | Second-side read strobe |
| s_wdata | input | DATA_W | Second-side write data |
| s_rst | input | 1 | Second processor held in reset (clears flags) |
| m_rdata | output | DATA_W | Byte read by the main side |
| s_rdata | output | DATA_W | Byte read by the second side |
| m_status | output | 4 | Main-side status word |
| s_status | output | 2 | Second-side status word |
| s_nmi | output | 1 | Interrupt pulse to the second processor |

## Verification
A wrong flag appears at the status ports in the cycle right after the strobe that updated it. A wrong latch appears only when the matching read returns a byte, which can be many cycles after the bad write. The bench therefore compares every output against a bench-side model after every cycle of mixed random and directed traffic. This covers same-cycle write/read collisions, unread overwrites and reset of the second processor during activity. A second instance built without the second processor confirms that its status word stays zero while the main side keeps working.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_FWD  = 0;  // main -> second
  localparam int unsigned LANE_REV  = 1;  // second -> main
  localparam int unsigned MSTAT_W   = 4;
  localparam int unsigned SSTAT_W   = 2;
endpackage

// File: rtl/ipc_mbox_lane.sv
module ipc_mbox_lane #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_flags,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              sent,
  output logic              taken
);
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      rdata   <= '0;
    end else begin
      if (wr) latch_q <= wdata;
      if (rd) rdata   <= latch_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_flags) begin
      sent  <= 1'b0;
      taken <= 1'b0;
    end else if (wr) begin
      sent  <= 1'b1;
      taken <= 1'b0;
    end else if (rd) begin
      sent  <= 1'b0;
      taken <= 1'b1;
    end
  end
endmodule

// File: rtl/ipc_nmi_pulse.sv
module ipc_nmi_pulse (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= trig;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter bit          SUB_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_wr,
  input  logic              m_rd,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic              s_wr,
  input  logic              s_rd,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_rst,
  output logic [DATA_W-1:0] m_rdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic [3:0]        m_status,
  output logic [1:0]        s_status,
  output logic              s_nmi
);
  logic              lane_wr    [NUM_LANES];
  logic              lane_rd    [NUM_LANES];
  logic [DATA_W-1:0] lane_wdata [NUM_LANES];
  logic [DATA_W-1:0] lane_rdata [NUM_LANES];
  logic              lane_sent  [NUM_LANES];
  logic              lane_taken [NUM_LANES];

  assign lane_wr[LANE_FWD]    = m_wr;
  assign lane_rd[LANE_FWD]    = s_rd;
  assign lane_wdata[LANE_FWD] = m_wdata;
  assign lane_wr[LANE_REV]    = s_wr;
  assign lane_rd[LANE_REV]    = m_rd;
  assign lane_wdata[LANE_REV] = s_wdata;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    ipc_mbox_lane #(.DATA_W(DATA_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .clr_flags (s_rst),
      .wr        (lane_wr[i]),
      .wdata     (lane_wdata[i]),
      .rd        (lane_rd[i]),
      .rdata     (lane_rdata[i]),
      .sent      (lane_sent[i]),
      .taken     (lane_taken[i])
    );
  end

  assign s_rdata = lane_rdata[LANE_FWD];
  assign m_rdata = lane_rdata[LANE_REV];

  // R9: main word carries second-taken and second-sent on bits 3 and 2
  assign m_status = {lane_taken[LANE_FWD], lane_sent[LANE_REV], 2'b00};

  if (SUB_PRESENT) begin : g_sub_stat
    assign s_status = {lane_taken[LANE_REV], lane_sent[LANE_FWD]};
  end else begin : g_no_sub_stat
    assign s_status = '0;  // R10
  end

  ipc_nmi_pulse u_nmi (
    .clk   (clk),
    .rst   (rst),
    .trig  (m_wr),
    .pulse (s_nmi)
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          SUB_PRESENT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              m_wr,
  input logic              m_rd,
  input logic [DATA_W-1:0] m_wdata,
  input logic              s_wr,
  input logic              s_rd,
  input logic              s_rst,
  input logic [DATA_W-1:0] s_rdata,
  input logic [3:0]        m_status,
  input logic [1:0]        s_status,
  input logic              s_nmi
);
  AST_NMI_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    m_wr |=> s_nmi); // R3
  AST_NMI_QUIET: assert property (@(posedge clk) disable iff (rst)
    !m_wr |=> !s_nmi); // R3
  AST_FWD_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (m_wr && !s_rst) |=> !m_status[3]); // R2
  AST_FWD_WRITE_SENT: assert property (@(posedge clk) disable iff (rst)
    (SUB_PRESENT && m_wr && !s_rst) |=> s_status[0]); // R2
  AST_FWD_READ_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (s_rd && !m_wr && !s_rst) |=> m_status[3]); // R4
  AST_REV_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (s_wr && !s_rst) |=> m_status[2]); // R5
  AST_REV_READ_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (m_rd && !s_wr && !s_rst) |=> !m_status[2]); // R6
  AST_SUB_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    s_rst |=> (m_status == 4'b0000 && s_status == 2'b00)); // R8
  AST_FWD_DATA_PATH: assert property (@(posedge clk) disable iff (rst)
    ($past(m_wr) && !m_wr && s_rd) |=> (s_rdata == $past(m_wdata, 2))); // R4
  AST_SRDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !s_rd |=> $stable(s_rdata)); // R12
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DATA_W(DATA_W), .SUB_PRESENT(SUB_PRESENT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .m_wr     (m_wr),
  .m_rd     (m_rd),
  .m_wdata  (m_wdata),
  .s_wr     (s_wr),
  .s_rd     (s_rd),
  .s_rst    (s_rst),
  .s_rdata  (s_rdata),
  .m_status (m_status),
  .s_status (s_status),
  .s_nmi    (s_nmi)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0, s_rst = 0;
  logic [DW-1:0] m_wdata = '0, s_wdata = '0;
  logic [DW-1:0] m_rdata, s_rdata, m_rdata_a, s_rdata_a;
  logic [3:0] m_status, m_status_a;
  logic [1:0] s_status, s_status_a;
  logic s_nmi, s_nmi_a;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side model
  logic [DW-1:0] e_fwd_lat, e_rev_lat, e_s_rdata, e_m_rdata;
  logic e_fwd_sent, e_fwd_taken, e_rev_sent, e_rev_taken, e_nmi;

  always #10 clk = ~clk;

  ipc_mailbox #(.DATA_W(DW), .SUB_PRESENT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
    .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata), .s_rst(s_rst),
    .m_rdata(m_rdata), .s_rdata(s_rdata), .m_status(m_status),
    .s_status(s_status), .s_nmi(s_nmi));

  ipc_mailbox #(.DATA_W(DW), .SUB_PRESENT(1'b0)) u_dut_abs (
    .clk(clk), .rst(rst), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
    .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata), .s_rst(s_rst),
    .m_rdata(m_rdata_a), .s_rdata(s_rdata_a), .m_status(m_status_a),
    .s_status(s_status_a), .s_nmi(s_nmi_a));

  function automatic logic [3:0] exp_mstat();
    return {e_fwd_taken, e_rev_sent, 2'b00};
  endfunction

  function automatic logic [1:0] exp_sstat();
    return {e_rev_taken, e_fwd_sent};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      e_fwd_lat = '0; e_rev_lat = '0; e_s_rdata = '0; e_m_rdata = '0;
      e_fwd_sent = 0; e_fwd_taken = 0; e_rev_sent = 0; e_rev_taken = 0; e_nmi = 0;
    end else begin
      if (s_rd) e_s_rdata = e_fwd_lat;
      if (m_rd) e_m_rdata = e_rev_lat;
      if (m_wr) e_fwd_lat = m_wdata;
      if (s_wr) e_rev_lat = s_wdata;
      e_nmi = m_wr;
      if (s_rst) begin
        e_fwd_sent = 0; e_fwd_taken = 0; e_rev_sent = 0; e_rev_taken = 0;
      end else begin
        if (m_wr)      begin e_fwd_sent = 1; e_fwd_taken = 0; end
        else if (s_rd) begin e_fwd_sent = 0; e_fwd_taken = 1; end
        if (s_wr)      begin e_rev_sent = 1; e_rev_taken = 0; end
        else if (m_rd) begin e_rev_sent = 0; e_rev_taken = 1; end
      end
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R9 m_status"}, {4'h0, m_status}, {4'h0, exp_mstat()});
    check({tag, " R9 s_status"}, {6'h0, s_status}, {6'h0, exp_sstat()});
    check({tag, " s_rdata"}, s_rdata, e_s_rdata);
    check({tag, " m_rdata"}, m_rdata, e_m_rdata);
    check({tag, " R3 s_nmi"}, {7'h0, s_nmi}, {7'h0, e_nmi});
    check({tag, " R10 absent s_status"}, {6'h0, s_status_a}, 8'h00);
    check({tag, " R10 absent m_status"}, {4'h0, m_status_a}, {4'h0, exp_mstat()});
    check({tag, " R10 absent m_rdata"}, m_rdata_a, e_m_rdata);
  endtask

  // inputs are applied right after a falling edge; outputs sampled at the next falling edge
  task automatic step(input logic mw, input logic mr, input logic [7:0] md,
                      input logic sw, input logic sr, input logic [7:0] sd,
                      input logic sx, input string tag);
    m_wr = mw; m_rd = mr; m_wdata = md; s_wr = sw; s_rd = sr; s_wdata = sd; s_rst = sx;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 8'h00, 0, 0, 8'h00, 0, tag);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst = 1;
    step(0, 0, 8'h00, 0, 0, 8'h00, 0, "R1 reset");
    step(1, 1, 8'hFF, 1, 1, 8'hEE, 0, "R1 reset ignores strobes");
    rst = 0;
    idle("R1 after reset");

    step(1, 0, 8'hA5, 0, 0, 8'h00, 0, "R2 main write");
    check("R3 nmi high once", {7'h0, s_nmi}, 8'h01);
    idle("R3 nmi drops");
    check("R3 nmi low", {7'h0, s_nmi}, 8'h00);
    step(0, 0, 8'h00, 0, 1, 8'h00, 0, "R4 second read");
    check("R4 s_rdata", s_rdata, 8'hA5);
    step(0, 0, 8'h00, 1, 0, 8'h3C, 0, "R5 second write");
    check("R5 m_status", {4'h0, m_status}, 8'h0C);
    step(0, 1, 8'h00, 0, 0, 8'h00, 0, "R6 main read");
    check("R6 m_rdata", m_rdata, 8'h3C);
    check("R6 s_status", {6'h0, s_status}, 8'h02);

    step(1, 0, 8'h11, 0, 0, 8'h00, 0, "R11 first write");
    step(1, 0, 8'h22, 0, 0, 8'h00, 0, "R11 overwrite");
    step(0, 0, 8'h00, 0, 1, 8'h00, 0, "R11 read newest");
    check("R11 s_rdata", s_rdata, 8'h22);

    step(1, 0, 8'h77, 0, 1, 8'h00, 0, "R7 fwd collide");
    check("R7 old byte", s_rdata, 8'h22);
    check("R7 sent wins", {6'h0, s_status}, 8'h03);
    step(0, 1, 8'h00, 1, 0, 8'h99, 0, "R7 rev collide");
    check("R7 rev old byte", m_rdata, 8'h3C);

    for (int k = 0; k < 3; k++) idle("R12 hold");
    check("R12 s_rdata hold", s_rdata, 8'h22);
    check("R12 m_rdata hold", m_rdata, 8'h3C);

    step(1, 1, 8'h55, 1, 1, 8'h66, 1, "R8 sub reset with strobes");
    check("R8 flags clear", {2'b00, m_status, s_status}, 8'h00);
    step(0, 0, 8'h00, 0, 0, 8'h00, 1, "R8 held");
    step(0, 0, 8'h00, 0, 1, 8'h00, 0, "R8 latch kept");
    check("R8 latch kept", s_rdata, 8'h55);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3], r[15:8], r[4] & r[5], r[6] & r[7], r[23:16],
           (r[31:27] == 5'd0), "random R2 R4 R5 R6 R7 R11");
    end

    rst = 1;
    step(1, 1, 8'h12, 1, 1, 8'h34, 0, "R1 late reset");
    rst = 0;
    idle("R1 after late reset");
    check("R1 cleared status", {2'b00, m_status, s_status}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule